// File: doc/BRIEF.md
# Micro-op Loop Sequencer for Tensor Compute

The sequencer carries out one compute instruction. It replays a contiguous list of micro-ops held in an external micro-op buffer, inside two nested hardware loops. For every micro-op in every iteration it forms three row addresses: accumulator, source and weight. Each address is the micro-op's own base index plus the outer iteration count times an outer factor plus the inner iteration count times an inner factor. Every buffer has its own pair of factors. The sequencer reads the addressed rows and writes one new accumulator row.

A micro-op runs in one of two modes. In matrix mode the accumulator row gains the product of an input vector and a weight matrix, all lanes signed. In vector mode a small lane-wise ALU combines the accumulator row with a second operand. That operand is either a second accumulator row or a sign-extended immediate. Any micro-op may instead clear its target row. Each micro-op runs a fetch, read, execute pass of three cycles. Its write lands before the next micro-op reads, so back-to-back updates of one row never see stale data. All buffers sit outside the block behind synchronous read ports with a latency of one cycle.

Top module: `uop_loop_seq`

## Requirements
- R1: For a start with outer count X, inner count Y and micro-op list entries B to E-1, exactly X*Y*(E-B) accumulator writes occur. They run with the outer counter slowest, the inner counter next and the list position fastest, and the list restarts at B for every inner pass.
- R2: For outer index i and inner index j, the accumulator, source and weight addresses equal base + i*factor_outer + j*factor_inner for that buffer, taken modulo 2^IDX_W.
- R3: Micro-op word layout: bit 0 is the mode, bit 1 is clear, then the destination, source and weight indices of IDX_W bits each, from the low end up. Mode 0 adds, for each output lane j, the sum over k of input lane k times weight element (j*BLK_IN+k) to accumulator lane j. All operands are signed, and results wrap to ACC_W bits. Lane n of a row sits at bits [n*W +: W].
- R4: Mode 1 reads its second operand from the accumulator buffer on the source read port at the source address. The input buffer is not used for it.
- R5: With the immediate flag set, the second operand of mode 1 is the 16-bit immediate sign-extended to ACC_W bits in every lane.
- R6: A micro-op with the clear bit set writes an all-zero row to its destination, whatever its mode.
- R7: ALU opcodes, applied lane-wise over signed values: 0 is add, 1 is accumulator minus operand, 2 is signed maximum, 3 is signed minimum.
- R8: `done` is high for exactly one cycle, 3*N+1 cycles after the clock edge that accepts `start`, where N is the number of micro-op executions. `busy` falls in the cycle after that.
- R9: A zero outer count, a zero inner count or an empty list (E <= B) produces no write. `done` then comes one cycle after the start edge.
- R10: `start` and the instruction inputs are ignored while `busy` is high. The running instruction completes unchanged.
- R11: After reset, `busy`, `done` and `acc_wr_en` are low.
- R12: A micro-op that reads a row written by the previous micro-op sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction when idle |
| uop_begin | input | UPTR_W | First micro-op entry |
| uop_end | input | UPTR_W | One past the last micro-op entry |
| ext_outer | input | EXT_W | Outer loop count |
| ext_inner | input | EXT_W | Inner loop count |
| dst_fac_outer | input | IDX_W | Accumulator outer factor |
| dst_fac_inner | input | IDX_W | Accumulator inner factor |
| src_fac_outer | input | IDX_W | Source outer factor |
| src_fac_inner | input | IDX_W | Source inner factor |
| wgt_fac_outer | input | IDX_W | Weight outer factor |
| wgt_fac_inner | input | IDX_W | Weight inner factor |
| alu_op | input | 2 | ALU opcode |
| use_imm | input | 1 | Use immediate as second ALU operand |
| imm | input | IMM_W | Signed immediate |
| uop_rd_addr | output | UPTR_W | Micro-op buffer read address |
| uop_rd_data | input | 2+3*IDX_W | Micro-op word, one cycle after address |
| acc_rd_addr | output | IDX_W | Accumulator read address (destination row) |
| acc_rd_data | input | BLK_OUT*ACC_W | Destination row data |
| src_rd_addr | output | IDX_W | Accumulator second read address |
| src_rd_data | input | BLK_OUT*ACC_W | Second accumulator row data |
| inp_rd_addr | output | IDX_W | Input buffer read address |
| inp_rd_data | input | BLK_IN*IN_W | Input vector |
| wgt_rd_addr | output | IDX_W | Weight buffer read address |
| wgt_rd_data | input | BLK_IN*BLK_OUT*WGT_W | Weight matrix |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_addr | output | IDX_W | Accumulator write address |
| acc_wr_data | output | BLK_OUT*ACC_W | Accumulator write row |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
One table of instructions drives the block with matrix-only lists, vector-only lists and a mixed list that clears, accumulates and adds into a single row. A result that is right for one mode but wrong for another shows up as a row mismatch. Factor sets with distinct values per buffer and loop tell apart swapped factors or swapped loop order. Large factors that wrap the address check that the modulo arithmetic wraps rather than saturates. The write-address log and the completion cycle check iteration count and timing on their own. Immediates of -5 and -32768 test sign extension, and all four opcodes check the lane-wise ALU.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_MAX = 2'd2,
      ALU_MIN = 2'd3
   } alu_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_EXEC,
      ST_DONE
   } seq_state_e;

   // micro-op word field positions
   localparam int UOP_MODE_BIT = 0;
   localparam int UOP_CLR_BIT  = 1;
   localparam int UOP_IDX_LSB  = 2;
   localparam int NUM_BUF      = 3;  // 0 dst, 1 src, 2 wgt
endpackage

// File: rtl/uop_loop_ctr.sv
module uop_loop_ctr #(
   parameter int EXT_W  = 14,
   parameter int UPTR_W = 10,
   parameter int IDX_W  = 11,
   parameter int NBUF   = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic                   step_i,
   input  logic [EXT_W-1:0]       ext0_i,
   input  logic [EXT_W-1:0]       ext1_i,
   input  logic [UPTR_W-1:0]      beg_i,
   input  logic [UPTR_W-1:0]      end_i,
   input  logic [NBUF*IDX_W-1:0]  f0_i,
   input  logic [NBUF*IDX_W-1:0]  f1_i,
   output logic [UPTR_W-1:0]      uptr_o,
   output logic [NBUF*IDX_W-1:0]  off_o,
   output logic                   final_o
);
   logic [EXT_W-1:0]      ext0_q, ext1_q, e0_q, e1_q;
   logic [UPTR_W-1:0]     beg_q, end_q, uptr_q;
   logic [NBUF*IDX_W-1:0] f0_q, f1_q;
   logic [IDX_W-1:0]      outer_q [NBUF];
   logic [IDX_W-1:0]      tot_q   [NBUF];
   logic last_uop, last_in, last_out;

   assign last_uop = (uptr_q == end_q - UPTR_W'(1));
   assign last_in  = (e1_q == ext1_q - EXT_W'(1));
   assign last_out = (e0_q == ext0_q - EXT_W'(1));
   assign final_o  = last_uop && last_in && last_out;
   assign uptr_o   = uptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext0_q <= '0; ext1_q <= '0; e0_q <= '0; e1_q <= '0;
         beg_q <= '0; end_q <= '0; uptr_q <= '0;
         f0_q <= '0; f1_q <= '0;
         for (int b = 0; b < NBUF; b++) begin
            outer_q[b] <= '0;
            tot_q[b]   <= '0;
         end
      end else if (load_i) begin
         ext0_q <= ext0_i; ext1_q <= ext1_i;
         beg_q <= beg_i; end_q <= end_i; uptr_q <= beg_i;
         f0_q <= f0_i; f1_q <= f1_i;
         e0_q <= '0; e1_q <= '0;
         for (int b = 0; b < NBUF; b++) begin
            outer_q[b] <= '0;
            tot_q[b]   <= '0;
         end
      end else if (step_i) begin
         if (!last_uop) begin
            uptr_q <= uptr_q + UPTR_W'(1);
         end else begin
            uptr_q <= beg_q;
            if (!last_in) begin
               e1_q <= e1_q + EXT_W'(1);
               for (int b = 0; b < NBUF; b++)
                  tot_q[b] <= tot_q[b] + f1_q[b*IDX_W +: IDX_W];
            end else begin
               e1_q <= '0;
               if (!last_out) begin
                  e0_q <= e0_q + EXT_W'(1);
                  for (int b = 0; b < NBUF; b++) begin
                     outer_q[b] <= outer_q[b] + f0_q[b*IDX_W +: IDX_W];
                     tot_q[b]   <= outer_q[b] + f0_q[b*IDX_W +: IDX_W];
                  end
               end
            end
         end
      end
   end

   for (genvar b = 0; b < NBUF; b++) begin : g_off
      assign off_o[b*IDX_W +: IDX_W] = tot_q[b];
   end

   // R1: every executed micro-op lies inside the programmed iteration space
   p_iter_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> (e0_q < ext0_q) && (e1_q < ext1_q) && (uptr_q >= beg_q) && (uptr_q < end_q));

   // R2: an inner step advances the inner counter by one and keeps the list start
   p_inner_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && last_uop && !last_in) |=> (e1_q == $past(e1_q) + EXT_W'(1)) && (uptr_q == beg_q));
endmodule

// File: rtl/uop_gemm_lanes.sv
module uop_gemm_lanes #(
   parameter int BLK_IN  = 16,
   parameter int BLK_OUT = 16,
   parameter int IN_W    = 8,
   parameter int WGT_W   = 8,
   parameter int ACC_W   = 32
) (
   input  logic [BLK_OUT*ACC_W-1:0]        acc_row_i,
   input  logic [BLK_IN*IN_W-1:0]          inp_row_i,
   input  logic [BLK_IN*BLK_OUT*WGT_W-1:0] wgt_mat_i,
   output logic [BLK_OUT*ACC_W-1:0]        res_row_o
);
   localparam int PW = IN_W + WGT_W;

   for (genvar j = 0; j < BLK_OUT; j++) begin : g_lane
      logic signed [ACC_W-1:0] sum;
      always_comb begin
         logic signed [PW-1:0] prod;
         sum = $signed(acc_row_i[j*ACC_W +: ACC_W]);
         for (int k = 0; k < BLK_IN; k++) begin
            prod = $signed(inp_row_i[k*IN_W +: IN_W]) *
                   $signed(wgt_mat_i[(j*BLK_IN+k)*WGT_W +: WGT_W]);
            sum  = sum + ACC_W'(prod);
         end
      end
      assign res_row_o[j*ACC_W +: ACC_W] = sum;
   end
endmodule

// File: rtl/uop_alu_lanes.sv
module uop_alu_lanes
   import uop_seq_pkg::*;
#(
   parameter int LANES = 16,
   parameter int ACC_W = 32
) (
   input  alu_op_e                op_i,
   input  logic                   use_imm_i,
   input  logic [ACC_W-1:0]       imm_i,
   input  logic [LANES*ACC_W-1:0] lhs_row_i,
   input  logic [LANES*ACC_W-1:0] rhs_row_i,
   output logic [LANES*ACC_W-1:0] res_row_o
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [ACC_W-1:0] a, b, r;
      assign a = $signed(lhs_row_i[l*ACC_W +: ACC_W]);
      assign b = use_imm_i ? $signed(imm_i) : $signed(rhs_row_i[l*ACC_W +: ACC_W]);
      always_comb begin
         unique case (op_i)
            ALU_ADD: r = a + b;
            ALU_SUB: r = a - b;
            ALU_MAX: r = (a > b) ? a : b;
            default: r = (a < b) ? a : b;
         endcase
      end
      assign res_row_o[l*ACC_W +: ACC_W] = r;
   end
endmodule

// File: rtl/uop_loop_seq.sv
module uop_loop_seq
   import uop_seq_pkg::*;
#(
   parameter int BLK_IN  = 16,
   parameter int BLK_OUT = 16,
   parameter int IN_W    = 8,
   parameter int WGT_W   = 8,
   parameter int ACC_W   = 32,
   parameter int IDX_W   = 11,
   parameter int UPTR_W  = 10,
   parameter int EXT_W   = 14,
   parameter int IMM_W   = 16,
   localparam int ACC_ROW = BLK_OUT*ACC_W,
   localparam int INP_ROW = BLK_IN*IN_W,
   localparam int WGT_MAT = BLK_IN*BLK_OUT*WGT_W,
   localparam int UOP_W   = UOP_IDX_LSB + NUM_BUF*IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [UPTR_W-1:0]  uop_begin,
   input  logic [UPTR_W-1:0]  uop_end,
   input  logic [EXT_W-1:0]   ext_outer,
   input  logic [EXT_W-1:0]   ext_inner,
   input  logic [IDX_W-1:0]   dst_fac_outer,
   input  logic [IDX_W-1:0]   dst_fac_inner,
   input  logic [IDX_W-1:0]   src_fac_outer,
   input  logic [IDX_W-1:0]   src_fac_inner,
   input  logic [IDX_W-1:0]   wgt_fac_outer,
   input  logic [IDX_W-1:0]   wgt_fac_inner,
   input  logic [1:0]         alu_op,
   input  logic               use_imm,
   input  logic [IMM_W-1:0]   imm,
   output logic [UPTR_W-1:0]  uop_rd_addr,
   input  logic [UOP_W-1:0]   uop_rd_data,
   output logic [IDX_W-1:0]   acc_rd_addr,
   input  logic [ACC_ROW-1:0] acc_rd_data,
   output logic [IDX_W-1:0]   src_rd_addr,
   input  logic [ACC_ROW-1:0] src_rd_data,
   output logic [IDX_W-1:0]   inp_rd_addr,
   input  logic [INP_ROW-1:0] inp_rd_data,
   output logic [IDX_W-1:0]   wgt_rd_addr,
   input  logic [WGT_MAT-1:0] wgt_rd_data,
   output logic               acc_wr_en,
   output logic [IDX_W-1:0]   acc_wr_addr,
   output logic [ACC_ROW-1:0] acc_wr_data,
   output logic               busy,
   output logic               done
);
   initial begin
      assert (ACC_W >= IN_W + WGT_W + $clog2(BLK_IN)) else $error("ACC_W too narrow for dot product");
      assert (IMM_W <= ACC_W) else $error("immediate wider than accumulator lane");
      assert (EXT_W >= 1 && UPTR_W >= 1 && IDX_W >= 1) else $error("bad index widths");
   end

   seq_state_e               state_q, state_d;
   alu_op_e                  op_q;
   logic                     use_imm_q, mode_q, clr_q;
   logic [ACC_W-1:0]         imm_ext_q;
   logic [IDX_W-1:0]         dst_q;
   logic [NUM_BUF*IDX_W-1:0] off, fac0, fac1;
   logic                     final_uop, empty, accept, step;
   logic [IDX_W-1:0]         dst_idx, src_idx, wgt_idx, src_addr;
   logic [ACC_ROW-1:0]       gemm_row, alu_row;

   assign fac0 = {wgt_fac_outer, src_fac_outer, dst_fac_outer};
   assign fac1 = {wgt_fac_inner, src_fac_inner, dst_fac_inner};
   assign empty  = (ext_outer == '0) || (ext_inner == '0) || (uop_end <= uop_begin);
   assign accept = (state_q == ST_IDLE) && start;
   assign step   = (state_q == ST_EXEC);

   uop_loop_ctr #(.EXT_W(EXT_W), .UPTR_W(UPTR_W), .IDX_W(IDX_W), .NBUF(NUM_BUF)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(step),
      .ext0_i(ext_outer), .ext1_i(ext_inner), .beg_i(uop_begin), .end_i(uop_end),
      .f0_i(fac0), .f1_i(fac1), .uptr_o(uop_rd_addr), .off_o(off), .final_o(final_uop));

   assign dst_idx  = uop_rd_data[UOP_IDX_LSB           +: IDX_W];
   assign src_idx  = uop_rd_data[UOP_IDX_LSB +   IDX_W +: IDX_W];
   assign wgt_idx  = uop_rd_data[UOP_IDX_LSB + 2*IDX_W +: IDX_W];
   assign src_addr = src_idx + off[IDX_W +: IDX_W];

   assign acc_rd_addr = dst_idx + off[0 +: IDX_W];
   assign src_rd_addr = src_addr;
   assign inp_rd_addr = src_addr;
   assign wgt_rd_addr = wgt_idx + off[2*IDX_W +: IDX_W];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start) state_d = empty ? ST_DONE : ST_FETCH;
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: state_d = ST_EXEC;
         ST_EXEC:   state_d = final_uop ? ST_DONE : ST_FETCH;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= ALU_ADD;
         use_imm_q <= 1'b0;
         imm_ext_q <= '0;
         mode_q    <= 1'b0;
         clr_q     <= 1'b0;
         dst_q     <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_q      <= alu_op_e'(alu_op);
            use_imm_q <= use_imm;
            imm_ext_q <= ACC_W'($signed(imm));
         end
         if (state_q == ST_DECODE) begin
            mode_q <= uop_rd_data[UOP_MODE_BIT];
            clr_q  <= uop_rd_data[UOP_CLR_BIT];
            dst_q  <= acc_rd_addr;
         end
      end
   end

   uop_gemm_lanes #(.BLK_IN(BLK_IN), .BLK_OUT(BLK_OUT), .IN_W(IN_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_gemm (
      .acc_row_i(acc_rd_data), .inp_row_i(inp_rd_data), .wgt_mat_i(wgt_rd_data), .res_row_o(gemm_row));

   uop_alu_lanes #(.LANES(BLK_OUT), .ACC_W(ACC_W)) u_alu (
      .op_i(op_q), .use_imm_i(use_imm_q), .imm_i(imm_ext_q),
      .lhs_row_i(acc_rd_data), .rhs_row_i(src_rd_data), .res_row_o(alu_row));

   assign acc_wr_en   = step;
   assign acc_wr_addr = dst_q;
   assign acc_wr_data = clr_q ? '0 : (mode_q ? alu_row : gemm_row);
   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);

   // R8: writes are separated by the fetch and read cycles of the next micro-op
   p_write_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr_en |=> !acc_wr_en);
   // R8: completion is a single cycle and releases busy
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   // R10: an instruction begins only from an accepted start
   p_start_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R1: no write outside an active instruction or during completion
   p_write_in_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wr_en |-> busy && !done);
endmodule

// File: tb/tb_uop_loop_seq.sv
module tb_uop_loop_seq;
   localparam int IDX_W = 8, UPTR_W = 4, EXT_W = 4, ACC_W = 32, NL = 16;
   localparam int ACC_ROW = NL*ACC_W, INP_ROW = NL*8, WGT_MAT = NL*NL*8;
   localparam int UOP_W = 2 + 3*IDX_W;

   typedef struct packed {
      logic [3:0] ext0, ext1, ubeg, uend;
      logic [7:0] df0, df1, sf0, sf1, wf0, wf1;
      logic [1:0] kind, op;
      logic       ui;
      logic [15:0] imm;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{4'd1,4'd1,4'd0,4'd2, 8'd0,8'd0,8'd0,8'd0,8'd0,8'd0, 2'd0,2'd0,1'b0,16'h0000},
      '{4'd2,4'd3,4'd2,4'd5, 8'd16,8'd4,8'd8,8'd1,8'd3,8'd7, 2'd0,2'd0,1'b0,16'h0000},
      '{4'd2,4'd2,4'd0,4'd3, 8'd8,8'd2,8'd1,8'd5,8'd0,8'd0, 2'd1,2'd0,1'b1,16'hFFFB},
      '{4'd1,4'd3,4'd1,4'd4, 8'd0,8'd1,8'd3,8'd2,8'd0,8'd0, 2'd1,2'd1,1'b0,16'h0000},
      '{4'd3,4'd1,4'd0,4'd2, 8'd5,8'd0,8'd9,8'd0,8'd0,8'd0, 2'd1,2'd2,1'b0,16'h0000},
      '{4'd2,4'd1,4'd0,4'd3, 8'd1,8'd0,8'd0,8'd0,8'd0,8'd0, 2'd1,2'd3,1'b1,16'd100},
      '{4'd2,4'd2,4'd0,4'd4, 8'd0,8'd0,8'd2,8'd1,8'd1,8'd1, 2'd2,2'd0,1'b0,16'h0000},
      '{4'd3,4'd2,4'd0,4'd4, 8'd200,8'd100,8'd150,8'd90,8'd120,8'd201, 2'd0,2'd0,1'b0,16'h0000},
      '{4'd2,4'd2,4'd0,4'd2, 8'd0,8'd0,8'd0,8'd0,8'd0,8'd0, 2'd1,2'd0,1'b1,16'h8000}
   };

   function automatic string vec_req(int i);
      case (i)
         0: return "R3";
         1: return "R1/R2/R3";
         2: return "R5/R7";
         3: return "R4/R7";
         4: return "R4/R7";
         5: return "R5/R7";
         6: return "R6/R12";
         7: return "R2";
         default: return "R5";
      endcase
   endfunction

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [UPTR_W-1:0] uop_begin = '0, uop_end = '0;
   logic [EXT_W-1:0] ext_outer = '0, ext_inner = '0;
   logic [IDX_W-1:0] df0 = '0, df1 = '0, sf0 = '0, sf1 = '0, wf0 = '0, wf1 = '0;
   logic [1:0] alu_op = '0;
   logic use_imm = 1'b0;
   logic [15:0] imm = '0;
   logic [UPTR_W-1:0] uop_rd_addr;
   logic [UOP_W-1:0] uop_rd_data;
   logic [IDX_W-1:0] acc_rd_addr, src_rd_addr, inp_rd_addr, wgt_rd_addr, acc_wr_addr;
   logic [ACC_ROW-1:0] acc_rd_data, src_rd_data, acc_wr_data;
   logic [INP_ROW-1:0] inp_rd_data;
   logic [WGT_MAT-1:0] wgt_rd_data;
   logic acc_wr_en, busy, done;

   always #4 clk = ~clk;

   uop_loop_seq #(.IDX_W(IDX_W), .UPTR_W(UPTR_W), .EXT_W(EXT_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .uop_begin(uop_begin), .uop_end(uop_end),
      .ext_outer(ext_outer), .ext_inner(ext_inner),
      .dst_fac_outer(df0), .dst_fac_inner(df1), .src_fac_outer(sf0), .src_fac_inner(sf1),
      .wgt_fac_outer(wf0), .wgt_fac_inner(wf1), .alu_op(alu_op), .use_imm(use_imm), .imm(imm),
      .uop_rd_addr(uop_rd_addr), .uop_rd_data(uop_rd_data),
      .acc_rd_addr(acc_rd_addr), .acc_rd_data(acc_rd_data),
      .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
      .inp_rd_addr(inp_rd_addr), .inp_rd_data(inp_rd_data),
      .wgt_rd_addr(wgt_rd_addr), .wgt_rd_data(wgt_rd_data),
      .acc_wr_en(acc_wr_en), .acc_wr_addr(acc_wr_addr), .acc_wr_data(acc_wr_data),
      .busy(busy), .done(done));

   logic [ACC_ROW-1:0] acc_mem [256];
   logic [ACC_ROW-1:0] exp_acc [256];
   logic [INP_ROW-1:0] inp_mem [256];
   logic [WGT_MAT-1:0] wgt_mem [256];
   logic [UOP_W-1:0]   uop_mem [16];
   logic [7:0] wr_log [64];
   logic [7:0] exp_log [64];
   int wr_cnt = 0, exp_n = 0, nchk = 0, nfail = 0;

   always @(posedge clk) begin
      uop_rd_data <= uop_mem[uop_rd_addr];
      acc_rd_data <= acc_mem[acc_rd_addr];
      src_rd_data <= acc_mem[src_rd_addr];
      inp_rd_data <= inp_mem[inp_rd_addr];
      wgt_rd_data <= wgt_mem[wgt_rd_addr];
      if (acc_wr_en) begin
         acc_mem[acc_wr_addr] <= acc_wr_data;
         if (wr_cnt < 64) wr_log[wr_cnt] <= acc_wr_addr;
         wr_cnt <= wr_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string msg);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic init_mems(input int seed, input logic [1:0] kind);
      for (int a = 0; a < 256; a++) begin
         for (int l = 0; l < NL; l++) begin
            acc_mem[a][l*32 +: 32] = 32'(a*37 + l*11 + seed*13 - 600);
            inp_mem[a][l*8 +: 8]   = 8'(a*7 + l*3 + seed);
         end
         for (int e = 0; e < NL*NL; e++)
            wgt_mem[a][e*8 +: 8] = 8'(a + e*5 + seed);
         exp_acc[a] = acc_mem[a];
      end
      for (int i = 0; i < 16; i++) begin
         logic [7:0] d, s, w;
         logic m, c;
         if (kind == 2'd2) begin
            d = 8'd4; s = 8'(i + 9); w = 8'(i*3 + 2); m = i[0]; c = (i == 0);
         end else begin
            d = 8'(i*2); s = 8'(i*5 + 1); w = 8'(i*3 + 2); m = (kind == 2'd1); c = 1'b0;
         end
         uop_mem[i] = {w, s, d, c, m};
      end
   endtask

   task automatic model(input vec_t v);
      exp_n = 0;
      for (int e0 = 0; e0 < int'(v.ext0); e0++)
         for (int e1 = 0; e1 < int'(v.ext1); e1++)
            for (int u = int'(v.ubeg); u < int'(v.uend); u++) begin
               logic [UOP_W-1:0] uw;
               logic [7:0] da, sa, wa;
               logic [ACC_ROW-1:0] nr;
               uw = uop_mem[u];
               da = 8'(int'(uw[9:2])   + e0*int'(v.df0) + e1*int'(v.df1));
               sa = 8'(int'(uw[17:10]) + e0*int'(v.sf0) + e1*int'(v.sf1));
               wa = 8'(int'(uw[25:18]) + e0*int'(v.wf0) + e1*int'(v.wf1));
               for (int j = 0; j < NL; j++) begin
                  int lhs, rhs, r;
                  lhs = $signed(exp_acc[da][j*32 +: 32]);
                  if (uw[1]) r = 0;
                  else if (!uw[0]) begin
                     r = lhs;
                     for (int k = 0; k < NL; k++)
                        r += int'($signed(inp_mem[sa][k*8 +: 8])) *
                             int'($signed(wgt_mem[wa][(j*NL+k)*8 +: 8]));
                  end else begin
                     rhs = v.ui ? int'($signed(v.imm)) : int'($signed(exp_acc[sa][j*32 +: 32]));
                     case (v.op)
                        2'd0: r = lhs + rhs;
                        2'd1: r = lhs - rhs;
                        2'd2: r = (lhs > rhs) ? lhs : rhs;
                        default: r = (lhs < rhs) ? lhs : rhs;
                     endcase
                  end
                  nr[j*32 +: 32] = r;
               end
               exp_acc[da] = nr;
               if (exp_n < 64) exp_log[exp_n] = da;
               exp_n++;
            end
   endtask

   task automatic run(input vec_t v, input int seed, input string req, input bit disturb);
      int n, ops;
      int bad;
      bit ok;
      init_mems(seed, v.kind);
      model(v);
      ops = int'(v.ext0) * int'(v.ext1) * ((v.uend > v.ubeg) ? int'(v.uend) - int'(v.ubeg) : 0);
      @(negedge clk);
      wr_cnt = 0;
      ext_outer = v.ext0; ext_inner = v.ext1; uop_begin = v.ubeg; uop_end = v.uend;
      df0 = v.df0; df1 = v.df1; sf0 = v.sf0; sf1 = v.sf1; wf0 = v.wf0; wf1 = v.wf1;
      alu_op = v.op; use_imm = v.ui; imm = v.imm;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!done && n < 600) begin
         if (disturb && n == 4) begin
            start = 1'b1; ext_outer = '0; alu_op = 2'd3; uop_begin = 4'd7; imm = 16'h1234;
            df0 = 8'd99; df1 = 8'd77;
         end
         if (disturb && n == 7) start = 1'b0;
         if (disturb && n == 5) chk(busy === 1'b1, $sformatf("R10 busy during run: got %b exp 1", busy));
         @(negedge clk);
         n++;
      end
      chk(n == 3*ops + 1, $sformatf("R8 %s done cycle: got %0d exp %0d", req, n, 3*ops + 1));
      @(negedge clk);
      chk(!done && !busy, $sformatf("R8 %s after done: got done=%b busy=%b exp 0 0", req, done, busy));
      chk(wr_cnt == exp_n, $sformatf("R1 %s write count: got %0d exp %0d", req, wr_cnt, exp_n));
      ok = 1'b1;
      for (int i = 0; i < exp_n && i < 64; i++)
         if (ok && wr_log[i] !== exp_log[i]) begin
            ok = 1'b0;
            chk(1'b0, $sformatf("R2 %s write %0d address: got %0d exp %0d", req, i, wr_log[i], exp_log[i]));
         end
      if (ok) chk(1'b1, "");
      bad = -1;
      for (int a = 0; a < 256; a++) if (bad < 0 && acc_mem[a] !== exp_acc[a]) bad = a;
      if (bad >= 0)
         chk(1'b0, $sformatf("%s row %0d: got %h exp %h", req, bad, acc_mem[bad], exp_acc[bad]));
      else chk(1'b1, "");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      vec_t dv;
      repeat (3) @(negedge clk);
      // R11: reset values
      chk(busy === 1'b0 && done === 1'b0 && acc_wr_en === 1'b0,
          $sformatf("R11 reset state: got busy=%b done=%b wr=%b exp 0 0 0", busy, done, acc_wr_en));
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0,
          $sformatf("R11 idle after reset: got busy=%b done=%b exp 0 0", busy, done));

      for (int i = 0; i < NV; i++) run(VECS[i], i + 1, vec_req(i), 1'b0);

      // R9: zero outer count
      dv = VECS[1]; dv.ext0 = 4'd0;
      run(dv, 20, "R9 zero outer", 1'b0);
      // R9: zero inner count
      dv = VECS[2]; dv.ext1 = 4'd0;
      run(dv, 21, "R9 zero inner", 1'b0);
      // R9: empty list
      dv = VECS[1]; dv.ubeg = 4'd5; dv.uend = 4'd5;
      run(dv, 22, "R9 empty list", 1'b0);
      // R10: start and inputs changed mid-run are ignored
      run(VECS[1], 23, "R10 disturbed", 1'b1);
      // R12: back-to-back writes to one row, single iteration
      dv = VECS[6]; dv.ext0 = 4'd1; dv.ext1 = 4'd1;
      run(dv, 24, "R12 single pass", 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule